// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is an n-bit register that a chip places between logic stages so that the same flip-flops serve both functional and self-test duty. A two-bit mode input picks one of four behaviours on each clock edge. The register can load its parallel inputs like any pipeline register, shift serially as part of a scan chain, clear itself, or compact a stream of parallel words into a signature. In the compaction mode it can also generate patterns.

In the compaction mode, stage 1 receives an XOR of selected stages. The TAPS parameter marks which stages take part, so it sets the feedback polynomial. Every other stage takes the stage before it XORed with its own parallel input bit. If the parallel inputs are held constant, the register steps through a linear feedback sequence and so acts as a pattern source for a neighbouring block. Test software usually does three things. It scans a seed in. It lets the register compact responses for a number of cycles. It then scans the signature out through the serial output and compares it with a known good value.

Top module: `bist_mode_reg`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge makes every stage 0 after that edge, whatever the mode.
- R2: With mode 2'b00 (shift) each edge moves stage k into stage k+1 and loads `scan_i` into stage 1. Stage k is `par_o[k-1]`. `scan_o` always shows stage n, which is `par_o[W-1]`.
- R3: With mode 2'b01 (clear) each edge sets every stage to 0, whatever `par_i` and `scan_i` hold.
- R4: With mode 2'b10 (compact) each edge loads stage k (k>1) with `par_i[k-1]` XOR the old stage k-1. Stage 1 is loaded with `par_i[0]` XOR the feedback bit.
- R5: With mode 2'b11 (load) each edge copies `par_i` into the register unchanged.
- R6: The feedback bit is the XOR of the old stages whose bit is set in TAPS, with TAPS bit k-1 standing for stage k. The default for W=8 is TAPS=8'hB1, which realises x^8+x^6+x^5+x+1.
- R7: In compact mode with `par_i` held at zero and a nonzero seed, the default register runs through a maximal sequence. A seed of 8'h01 comes back for the first time after exactly 255 edges.
- R8: The mode is sampled at the same edge as the data. A change of `mode_i` between edges therefore governs only the next edge, and earlier contents are left as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Mode: 00 shift, 01 clear, 10 compact, 11 load |
| par_i | input | W | Parallel data input, bit k-1 feeds stage k |
| scan_i | input | 1 | Serial input into stage 1 |
| par_o | output | W | Register contents, bit k-1 is stage k |
| scan_o | output | 1 | Serial output from stage n |

## Verification
Compaction is tried with a run of distinct, changing words so that the parallel XOR paths and the tapped feedback are both exercised. A complete scan-in, compact and scan-out session then shows that the serial output delivers the same signature a software model computes. Compaction with zero inputs from a seed of one separates a correct tap set from a wrong one by the period it yields. Alternating load, clear and shift on consecutive edges, together with a reset during a load, shows that each edge obeys only the mode present at that edge.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_SIG   = 2'b10,
        MODE_LOAD  = 2'b11
    } mode_e;

    // Per-stage control: next = (use_prev & prev) ^ (use_par & par)
    typedef struct packed {
        logic use_prev;
        logic use_par;
    } cell_ctl_t;

    function automatic cell_ctl_t decode_mode(input mode_e m);
        cell_ctl_t c;
        case (m)
            MODE_SHIFT: c = '{use_prev: 1'b1, use_par: 1'b0};
            MODE_CLEAR: c = '{use_prev: 1'b0, use_par: 1'b0};
            MODE_SIG:   c = '{use_prev: 1'b1, use_par: 1'b1};
            default:    c = '{use_prev: 1'b0, use_par: 1'b1};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bmr_feedback.sv
module bmr_feedback #(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB1
) (
    input  logic [W-1:0] q_i,
    output logic         fb_o
);
    logic [W-1:0] masked;

    for (genvar g = 0; g < W; g++) begin : g_tap
        if (TAPS[g]) begin : g_on
            assign masked[g] = q_i[g];
        end else begin : g_off
            assign masked[g] = 1'b0;
        end
    end

    assign fb_o = ^masked;
endmodule

// File: rtl/bmr_head.sv
module bmr_head
    import bmr_pkg::*;
(
    input  mode_e mode_i,
    input  logic  scan_i,
    input  logic  fb_i,
    output logic  head_o
);
    always_comb begin
        if (mode_i == MODE_SHIFT) head_o = scan_i;
        else                      head_o = fb_i;
    end
endmodule

// File: rtl/bmr_cell.sv
module bmr_cell
    import bmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cell_ctl_t ctl_i,
    input  logic      par_i,
    input  logic      prev_i,
    output logic      q_o
);
    logic nxt;

    always_comb nxt = (ctl_i.use_prev & prev_i) ^ (ctl_i.use_par & par_i);

    always_ff @(posedge clk) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= nxt;
    end
endmodule

// File: rtl/bist_mode_reg.sv
module bist_mode_reg
    import bmr_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode_i,
    input  logic [W-1:0] par_i,
    input  logic         scan_i,
    output logic [W-1:0] par_o,
    output logic         scan_o
);
    localparam int LAST = W - 1;

    mode_e        mode;
    cell_ctl_t    ctl;
    logic [W-1:0] q;
    logic [W-1:0] prev;
    logic         fb;
    logic         head;

    assign mode = mode_e'(mode_i);
    assign ctl  = decode_mode(mode);

    bmr_feedback #(.W(W), .TAPS(TAPS)) u_fb (
        .q_i  (q),
        .fb_o (fb)
    );

    bmr_head u_head (
        .mode_i (mode),
        .scan_i (scan_i),
        .fb_i   (fb),
        .head_o (head)
    );

    assign prev = {q[LAST-1:0], head};

    for (genvar g = 0; g < W; g++) begin : g_stage
        bmr_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .ctl_i  (ctl),
            .par_i  (par_i[g]),
            .prev_i (prev[g]),
            .q_o    (q[g])
        );
    end

    assign par_o  = q;
    assign scan_o = q[LAST];

    // R1: reset clears all stages
    p_reset_zero_r1: assert property (@(posedge clk)
        rst |=> par_o == '0);

    // R2: serial shift
    p_shift_r2: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b00 |=> par_o == {$past(par_o[LAST-1:0]), $past(scan_i)});

    // R3: clear mode
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b01 |=> par_o == '0);

    // R4: compaction of upper stages
    p_sig_chain_r4: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b10 |=> par_o[LAST:1] == ($past(par_i[LAST:1]) ^ $past(par_o[LAST-1:0])));

    // R6: stage 1 takes input XOR tapped parity
    p_sig_head_r6: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b10 |=> par_o[0] == ($past(par_i[0]) ^ (^($past(par_o) & TAPS))));

    // R5: parallel load
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        mode_i == 2'b11 |=> par_o == $past(par_i));
endmodule

// File: tb/test_bist_mode_reg.sv
`timescale 1ns/1ps
module test_bist_mode_reg;
    localparam int           W    = 8;
    localparam logic [W-1:0] TAPS = 8'hB1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode_i = 2'b11;
    logic [W-1:0] par_i = '0;
    logic         scan_i = 1'b0;
    logic [W-1:0] par_o;
    logic         scan_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [W-1:0] model = '0;

    always #10 clk = ~clk;

    bist_mode_reg #(.W(W), .TAPS(TAPS)) i_bist_mode_reg (
        .clk(clk), .rst(rst), .mode_i(mode_i), .par_i(par_i),
        .scan_i(scan_i), .par_o(par_o), .scan_o(scan_o)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Behavioural next-state model, one clock edge
    function automatic logic [W-1:0] ref_next(input logic [W-1:0] cur, input logic r,
                                              input logic [1:0] md, input logic [W-1:0] pv,
                                              input logic si);
        logic [W-1:0] n;
        int ones;
        if (r) return '0;
        case (md)
            2'b00: n = (cur << 1) | W'(si);
            2'b01: n = '0;
            2'b11: n = pv;
            default: begin
                ones = 0;
                for (int k = 0; k < W; k++) if (TAPS[k] && cur[k]) ones++;
                n = ((cur << 1) | W'(ones % 2)) ^ pv;
            end
        endcase
        return n;
    endfunction

    task automatic step(input logic [1:0] md, input logic [W-1:0] pv, input logic si,
                        input logic r, input string tag);
        @(negedge clk);
        mode_i = md; par_i = pv; scan_i = si; rst = r;
        @(posedge clk);
        model = ref_next(model, r, md, pv, si);
        #5;
        check(par_o === model, tag, par_o, model);
        check(scan_o === model[W-1], {tag, " scan_o"}, W'(scan_o), W'(model[W-1]));
    endtask

    initial begin
        logic [W-1:0] sig;
        logic [W-1:0] seen;
        int period;

        // R1: reset state
        step(2'b11, 8'h5A, 1'b1, 1'b1, "R1 reset");
        step(2'b11, 8'hC3, 1'b0, 1'b1, "R1 reset");
        check(par_o === '0, "R1 reset value", par_o, '0);

        // R5: parallel load
        step(2'b11, 8'hA5, 1'b0, 1'b0, "R5 load");
        step(2'b11, 8'h3C, 1'b1, 1'b0, "R5 load");

        // R3: clear ignores inputs
        step(2'b01, 8'hFF, 1'b1, 1'b0, "R3 clear");
        check(par_o === '0, "R3 cleared", par_o, '0);

        // R8: mode changes on consecutive edges
        step(2'b11, 8'h96, 1'b0, 1'b0, "R8 load");
        step(2'b00, 8'h00, 1'b1, 1'b0, "R8 shift after load");
        step(2'b01, 8'hFF, 1'b1, 1'b0, "R8 clear after shift");
        step(2'b11, 8'h71, 1'b0, 1'b0, "R8 load after clear");
        step(2'b10, 8'h0F, 1'b0, 1'b0, "R8 compact after load");

        // R2: scan in seed 8'hD2, MSB first
        for (int i = W - 1; i >= 0; i--) step(2'b00, 8'hEE, (8'hD2 >> i) & 1'b1, 1'b0, "R2 scan in");
        check(par_o === 8'hD2, "R2 seed", par_o, 8'hD2);

        // R4/R6: compaction of changing words
        for (int i = 0; i < 12; i++) step(2'b10, W'(i * 37 + 5), 1'b0, 1'b0, "R4 R6 compact");
        sig = model;

        // R2: scan out signature, MSB first on scan_o
        seen = '0;
        for (int i = 0; i < W; i++) begin
            seen = (seen << 1) | W'(scan_o);
            step(2'b00, 8'h00, 1'b0, 1'b0, "R2 scan out");
        end
        check(seen === sig, "R2 serial signature", seen, sig);

        // R1: reset during load
        step(2'b11, 8'hBE, 1'b0, 1'b0, "R1 pre");
        step(2'b11, 8'hEF, 1'b0, 1'b1, "R1 reset in load");

        // R7: maximal sequence from seed 1
        step(2'b11, 8'h01, 1'b0, 1'b0, "R7 seed");
        period = 0;
        for (int i = 1; i <= 300; i++) begin
            step(2'b10, 8'h00, 1'b0, 1'b0, "R7 pattern");
            if (par_o === 8'h01) begin
                period = i;
                break;
            end
        end
        check(period == 255, "R7 period", W'(period), W'(255));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule